// File: doc/BRIEF.md
# T1 Ones-Density Violation Monitor

This block watches the received bit stream of a T1 line, one bit per clock enable, and reports ones-density violations. Two rule sets apply, picked by whether zero-substitution (B8ZS) line coding is in use. With plain coding, a run of sixteen zeros is a violation. So is any trailing window of 8(N+1) bits that holds fewer than N ones, for every N from 1 to 23. With B8ZS coding, only a run of eight zeros counts.

The window rule is enforced by tracking the age, in received bits, of each of the 23 most recent ones. The N-th most recent one falling out of its 8(N+1)-bit window means a violation for that N. The window rule only starts to count once 192 bits have arrived since reset or since the last change of coding mode. Every violating bit produces a one-cycle pulse. Each pulse also sets a sticky status bit, unless a mask input holds it off. A host read strobe clears the status bit.

Top module: `t1_density_mon`

## Requirements
- R1: With plain coding, the pulse is raised for the 16th consecutive zero and for every further zero of the same run. It is not raised for the 15th.
- R2: With plain coding, and once warmed up, the pulse is raised for a bit when, for some N in 1..23, the last 8(N+1) bits (this one included) hold fewer than N ones.
- R3: With B8ZS coding, the pulse is raised only for the 8th and later consecutive zeros. The window rule of R2 is not applied.
- R4: The window rule is suppressed until at least 192 bits, counting the current one, have arrived since reset or since the last mode change.
- R5: The coding mode input is sampled only with a bit enable. A change of mode seen at a bit enable restarts the zero-run count, with the current bit counted anew. A mode toggle between bit enables has no effect.
- R6: `viol_pulse` is high for exactly the one cycle after a clock edge where a violating bit was accepted. It is low in every cycle that follows an edge without a bit enable.
- R7: A violation with `viol_mask` low sets `viol_status` at the same edge where the pulse rises. With `viol_mask` high, the status is left unchanged.
- R8: `status_rd` high at an edge clears `viol_status`. If an unmasked violation is accepted at that same edge, the status stays set.
- R9: After reset, `viol_pulse` and `viol_status` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One received bit is valid this cycle |
| rx_bit | input | 1 | Received line bit (1 = mark) |
| b8zs_on | input | 1 | 1 = B8ZS coding rules, 0 = plain coding rules |
| viol_mask | input | 1 | 1 = violations do not set the status bit |
| status_rd | input | 1 | Host read strobe, clears the status bit |
| viol_pulse | output | 1 | One-cycle pulse per violating bit |
| viol_status | output | 1 | Sticky violation status |

## Verification
Several repeating patterns of a one followed by a fixed number of zeros are fed in under both coding modes. Each result is compared bit by bit against a bench model that counts ones in explicit windows. A one-in-four pattern and a one-in-eight pattern tell a correct window threshold apart from an off-by-one. The one-in-eight pattern never violates, while a one-in-ten pattern violates only through the wide windows. Directed runs of exactly 15 and 16 zeros, and of 7 and 8 zeros, separate the two run limits. A one-in-ten pattern read at bits 191 and 192 pins the warm-up edge. Mode toggles, both between enables and at an enable, show whether the run count restarts.

// File: rtl/t1dm_pkg.sv
package t1dm_pkg;
  localparam int unsigned DEF_NMAX      = 23;  // largest N of the window rule
  localparam int unsigned DEF_BLK       = 8;   // window is BLK*(N+1) bits
  localparam int unsigned DEF_LONG_RUN  = 16;  // zero run limit, plain coding
  localparam int unsigned DEF_SHORT_RUN = 8;   // zero run limit, B8ZS coding
  localparam int unsigned DEF_WARM_BITS = 192; // bits before window rule counts
endpackage

// File: rtl/t1dm_run_ctr.sv
module t1dm_run_ctr #(
  parameter int unsigned LONG_RUN  = 16,
  parameter int unsigned SHORT_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic mode_chg,
  input  logic b8zs,
  output logic run_viol
);
  localparam int unsigned RUN_W = $clog2(LONG_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] LIM_LONG  = RUN_W'(LONG_RUN);
  localparam logic [RUN_W-1:0] LIM_SHORT = RUN_W'(SHORT_RUN);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (rx_bit)
      run_d = '0;
    else if (mode_chg)
      run_d = RUN_W'(1);
    else if (run_q == RUN_MAX)
      run_d = run_q;
    else
      run_d = run_q + RUN_W'(1);
    run_viol = run_d >= (b8zs ? LIM_SHORT : LIM_LONG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (bit_en)
      run_q <= run_d;
  end
endmodule

// File: rtl/t1dm_window.sv
module t1dm_window #(
  parameter int unsigned NMAX      = 23,
  parameter int unsigned BLK       = 8,
  parameter int unsigned WARM_BITS = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic mode_chg,
  input  logic rule_on,
  output logic win_viol
);
  localparam int unsigned W_MAX  = BLK * (NMAX + 1);
  localparam int unsigned AGE_W  = $clog2(W_MAX + 1);
  localparam int unsigned WARM_W = $clog2(WARM_BITS + 1);
  localparam logic [AGE_W-1:0]  AGE_SAT  = '1;
  localparam logic [WARM_W-1:0] WARM_LIM = WARM_W'(WARM_BITS);

  function automatic logic [AGE_W-1:0] age_inc(input logic [AGE_W-1:0] a);
    return (a == AGE_SAT) ? a : a + AGE_W'(1);
  endfunction

  logic [AGE_W-1:0]  age_q [NMAX];
  logic [AGE_W-1:0]  age_d [NMAX];
  logic [NMAX-1:0]   late;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic              ready;

  // age_d[i]: bits elapsed since the (i+1)-th most recent one, current bit included
  always_comb begin
    age_d[0] = rx_bit ? '0 : age_inc(age_q[0]);
    for (int i = 1; i < NMAX; i++)
      age_d[i] = rx_bit ? age_inc(age_q[i-1]) : age_inc(age_q[i]);
  end

  for (genvar gi = 0; gi < NMAX; gi++) begin : g_limit
    assign late[gi] = age_d[gi] >= AGE_W'(BLK * (gi + 2));
  end

  always_comb begin
    if (mode_chg)
      warm_d = WARM_W'(1);
    else if (warm_q >= WARM_LIM)
      warm_d = warm_q;
    else
      warm_d = warm_q + WARM_W'(1);
    ready    = warm_d >= WARM_LIM;
    win_viol = rule_on && ready && (|late);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      for (int i = 0; i < NMAX; i++)
        age_q[i] <= AGE_SAT;
    end else if (bit_en) begin
      warm_q <= warm_d;
      for (int i = 0; i < NMAX; i++)
        age_q[i] <= age_d[i];
    end
  end
endmodule

// File: rtl/t1dm_status.sv
module t1dm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_now,
  input  logic mask,
  input  logic rd,
  output logic status
);
  logic stat_q, stat_d;

  always_comb
    stat_d = (viol_now && !mask) || (stat_q && !rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= 1'b0;
    else
      stat_q <= stat_d;
  end

  assign status = stat_q;
endmodule

// File: rtl/t1_density_mon.sv
module t1_density_mon
  import t1dm_pkg::*;
#(
  parameter int unsigned NMAX      = DEF_NMAX,
  parameter int unsigned BLK       = DEF_BLK,
  parameter int unsigned LONG_RUN  = DEF_LONG_RUN,
  parameter int unsigned SHORT_RUN = DEF_SHORT_RUN,
  parameter int unsigned WARM_BITS = DEF_WARM_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic b8zs_on,
  input  logic viol_mask,
  input  logic status_rd,
  output logic viol_pulse,
  output logic viol_status
);
  logic mode_q, mode_d;
  logic mode_chg;
  logic run_viol, win_viol;
  logic viol_now;
  logic pulse_q, pulse_d;

  always_comb begin
    mode_chg = b8zs_on != mode_q;
    mode_d   = bit_en ? b8zs_on : mode_q;
    viol_now = bit_en && (run_viol || win_viol);
    pulse_d  = viol_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  t1dm_run_ctr #(.LONG_RUN(LONG_RUN), .SHORT_RUN(SHORT_RUN)) run_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .mode_chg(mode_chg), .b8zs(b8zs_on), .run_viol(run_viol)
  );

  t1dm_window #(.NMAX(NMAX), .BLK(BLK), .WARM_BITS(WARM_BITS)) win_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .mode_chg(mode_chg), .rule_on(!b8zs_on), .win_viol(win_viol)
  );

  t1dm_status stat_i (
    .clk(clk), .rst_n(rst_n), .viol_now(viol_now), .mask(viol_mask),
    .rd(status_rd), .status(viol_status)
  );

  assign viol_pulse = pulse_q;
endmodule

// File: rtl/t1dm_checker.sv
module t1dm_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic viol_mask,
  input logic status_rd,
  input logic viol_pulse,
  input logic viol_status
);
  // R6: no pulse after an edge without an accepted bit
  p_pulse_needs_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !viol_pulse);

  // R7: status only rises together with a pulse
  p_status_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_status) |-> viol_pulse);

  // R7: an unmasked pulse leaves the status set
  p_unmasked_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && !$past(viol_mask)) |-> viol_status);

  // R8: a read clears unless a violation coincides
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (!viol_status || viol_pulse));

  // R8: status is sticky without a read
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_status && !status_rd) |=> viol_status);
endmodule

bind t1_density_mon t1dm_checker chk_i (.*);

// File: tb/t1_density_mon_tb.sv
`timescale 1ns/1ps
module t1_density_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, b8zs_on, viol_mask, status_rd;
  logic viol_pulse, viol_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  t1_density_mon dut_i (.*);

  // bench reference model
  logic [191:0] hist;
  int  m_run, m_since;
  logic m_mode, exp_stat, last_pulse;

  // segment table: {b8zs[25], mask[24], zeros_after_one[23:16], length[15:0]}
  localparam int NSEG = 7;
  localparam logic [25:0] SEG [NSEG] = '{
    {1'b0, 1'b0, 8'd3,  16'd300},
    {1'b0, 1'b0, 8'd9,  16'd400},
    {1'b1, 1'b0, 8'd6,  16'd200},
    {1'b1, 1'b0, 8'd9,  16'd100},
    {1'b0, 1'b1, 8'd12, 16'd400},
    {1'b0, 1'b0, 8'd7,  16'd300},
    {1'b0, 1'b0, 8'd20, 16'd100}
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_step(input logic b);
    logic ev;
    if (b8zs_on != m_mode) begin
      m_mode  = b8zs_on;
      m_run   = 0;
      m_since = 0;
    end
    m_run   = b ? 0 : ((m_run < 1000) ? m_run + 1 : m_run);
    m_since = (m_since < 1000) ? m_since + 1 : m_since;
    hist    = {hist[190:0], b};
    ev      = m_run >= (m_mode ? 8 : 16);
    if (!m_mode && m_since >= 192) begin
      for (int n = 1; n <= 23; n++) begin
        int cnt = 0;
        for (int k = 0; k < 8 * (n + 1); k++) cnt += int'(hist[k]);
        if (cnt < n) ev = 1'b1;
      end
    end
    return ev;
  endfunction

  task automatic send_bit(input logic b, input logic rd, input string req);
    logic ev;
    @(negedge clk);
    rx_bit = b; bit_en = 1'b1; status_rd = rd;
    ev = model_step(b);
    exp_stat = (ev && !viol_mask) || (exp_stat && !rd);
    @(negedge clk);
    bit_en = 1'b0; status_rd = 1'b0;
    last_pulse = viol_pulse;
    check(viol_pulse, ev, req);
    check(viol_status, exp_stat, "R7/R8 status");
    @(negedge clk);
    check(viol_pulse, 1'b0, "R6 pulse width");
  endtask

  task automatic do_read();
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    exp_stat = 1'b0;
    check(viol_status, 1'b0, "R8 read clear");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; b8zs_on = 1'b0;
    viol_mask = 1'b0; status_rd = 1'b0;
    hist = '0; m_run = 0; m_since = 0; m_mode = 1'b0; exp_stat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(viol_pulse, 1'b0, "R9 reset pulse");
    check(viol_status, 1'b0, "R9 reset status");
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; b8zs_on = 1'b0;
    viol_mask = 1'b0; status_rd = 1'b0; last_pulse = 1'b0;
    do_reset();

    // table walk, each bit compared with the model (R1 R2 R3 R4)
    for (int s = 0; s < NSEG; s++) begin
      b8zs_on   = SEG[s][25];
      viol_mask = SEG[s][24];
      for (int k = 0; k < int'(SEG[s][15:0]); k++)
        send_bit((k % (int'(SEG[s][23:16]) + 1)) == 0, 1'b0, "R1/R2/R3 pattern");
      do_read();
    end

    // R1: 15 zeros quiet, 16th flags
    do_reset();
    for (int k = 1; k <= 16; k++) begin
      send_bit(1'b0, 1'b0, "R1 run");
      if (k == 15) check(last_pulse, 1'b0, "R1 15th zero");
      if (k == 16) check(last_pulse, 1'b1, "R1 16th zero");
    end

    // R4: one-in-ten after reset, window rule starts at bit 192
    do_reset();
    for (int k = 0; k < 192; k++) begin
      send_bit((k % 10) == 0, 1'b0, "R4 warm-up");
      if (k == 190) check(last_pulse, 1'b0, "R4 bit 191");
      if (k == 191) check(last_pulse, 1'b1, "R2 bit 192");
    end

    // R5: mode toggle between enables leaves the run intact
    do_reset();
    repeat (10) send_bit(1'b0, 1'b0, "R5 prefix");
    @(negedge clk); b8zs_on = 1'b1;
    @(negedge clk); b8zs_on = 1'b0;
    for (int k = 11; k <= 16; k++) begin
      send_bit(1'b0, 1'b0, "R5 toggle");
      if (k == 15) check(last_pulse, 1'b0, "R5 15th zero");
      if (k == 16) check(last_pulse, 1'b1, "R5 16th zero");
    end

    // R3 and R5: mode change at an enable restarts the run under the 8 limit
    do_reset();
    repeat (10) send_bit(1'b0, 1'b0, "R5 prefix");
    b8zs_on = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      send_bit(1'b0, 1'b0, "R3 run");
      if (k == 7) check(last_pulse, 1'b0, "R3 7th zero after change");
      if (k == 8) check(last_pulse, 1'b1, "R3 8th zero");
    end

    // R8: read coinciding with a violation keeps status
    do_reset();
    repeat (15) send_bit(1'b0, 1'b0, "R8 prefix");
    send_bit(1'b0, 1'b1, "R8 coincide");
    check(viol_status, 1'b1, "R8 status kept");
    do_read();

    // R7: masked violation pulses but leaves status clear
    do_reset();
    viol_mask = 1'b1;
    repeat (16) send_bit(1'b0, 1'b0, "R7 masked");
    check(last_pulse, 1'b1, "R7 masked pulse");
    check(viol_status, 1'b0, "R7 masked status");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule